// File: doc/BRIEF.md
# Receive Frame Checker and Region Router

This block sits on the receive side of a Fibre Channel port, after the 8b/10b decoder. It takes a stream of decoded 32-bit words in which the first word of a frame carries a start flag and the last word carries an end flag. The block strips the delimiters. It writes the header and payload words into an on-chip receive buffer and checks the frame as it arrives. Only frames that pass every check become visible to the consumer.

The receive buffer has four regions: general traffic, data, command and response. The region is picked from the routing-control byte of the first header word. Each region is a ring of fixed-size frame slots. A frame is written into the ring's tail slot tentatively. The tail pointer advances only when the frame ends cleanly, so a rejected frame leaves no trace.

The block also tracks buffer-to-buffer credit, which is the number of free slots. It asks for a receiver-ready primitive each time a consumer frees a slot.

Top module: `rxfr_router`

## Requirements
- R1: The word flagged as start is header word 0. The word flagged as end is the CRC word and is not stored. Header and payload words are stored at slot offsets 0, 1, 2, … in arrival order. The reported length `cmt_len` is the number of payload words, that is, the words before the CRC word minus `HDR_WORDS`.
- R2: The CRC word must equal a CRC-32 computed over every header and payload word. The CRC uses polynomial 0x04C11DB7 and initial value 0xFFFFFFFF, has no final inversion, and processes each word from bit 31 down to bit 0. A frame with a mismatching CRC is discarded and not committed.
- R3: A frame is discarded in either of two cases: it has more than `MAX_PAY_WORDS` payload words, or it has fewer than `HDR_WORDS` words before its CRC word. A single word carrying both flags is one such short frame.
- R4: A start word that arrives while a frame is still open abandons the open frame without committing it. The new frame is then handled normally.
- R5: The routing-control byte is bits 31:24 of header word 0. It selects the region as follows: 0x01 goes to region 1 (data), 0x06 to region 2 (command), 0x07 to region 3 (response), and any other value to region 0 (general).
- R6: In the cycle after the clock edge that samples a valid end word, `cmt_valid` is high for one cycle. In that same cycle the block reports the region, the slot index and the payload length. Discarded frames raise no `cmt_valid`.
- R7: A frame whose target region already holds `NSLOT` committed frames when its start word arrives is dropped whole. `ovf_count` rises by one and the credit is unchanged.
- R8: A release on `rel_valid`/`rel_region` to a non-empty region frees that region's oldest slot. One cycle later `rrdy_req` is high for exactly one cycle and the credit has risen by one. A release to an empty region changes nothing.
- R9: After reset the credit equals 4·`NSLOT`, `ovf_count` is 0, and `cmt_valid` and `rrdy_req` are low. Each commit lowers the credit by one.
- R10: One cycle after `rd_region`, `rd_slot` and `rd_word` are applied, `rd_data` holds that stored word.
- R11: Valid words that arrive while no frame is open and that carry no start flag are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Word on `in_data` is valid |
| in_sof | input | 1 | Word is the first word of a frame |
| in_eof | input | 1 | Word is the CRC word ending a frame |
| in_data | input | 32 | Decoded word |
| rel_valid | input | 1 | Consumer frees the oldest slot of `rel_region` |
| rel_region | input | 2 | Region to release |
| rd_region | input | 2 | Read region |
| rd_slot | input | SLOT_W | Read slot |
| rd_word | input | OFF_W | Word offset within the slot |
| rd_data | output | 32 | Read data, one cycle latency |
| cmt_valid | output | 1 | A frame was committed |
| cmt_region | output | 2 | Region of the committed frame |
| cmt_slot | output | SLOT_W | Slot of the committed frame |
| cmt_len | output | OFF_W | Payload words of the committed frame |
| rrdy_req | output | 1 | Send one receiver-ready primitive |
| credit | output | CRED_W | Free slots (buffer-to-buffer credit) |
| ovf_count | output | OVF_W | Frames dropped because the region was full |

## Verification
The bench builds the block with `HDR_WORDS`=6, `MAX_PAY_WORDS`=8 and `NSLOT`=2. With those values a slot is 14 words, so both the maximum-length frame (8 payload words) and the one-word-too-long frame (9) are cheap to drive. A region fills after only two commits, which makes overflow, credit exhaustion per region and pointer wrap-around quick to reach. The vector table covers each routing value, a CRC error, a frame that is too long and an abandoned frame. The directed tests cover overflow, read-back of stored words, releases to full and to empty regions, frames that are too short and stray words.

// File: rtl/rxfr_pkg.sv
package rxfr_pkg;
  localparam int NREG = 4;
  typedef logic [1:0] region_t;

  localparam region_t RG_GEN  = 2'd0;
  localparam region_t RG_DATA = 2'd1;
  localparam region_t RG_CMD  = 2'd2;
  localparam region_t RG_RSP  = 2'd3;

  localparam logic [7:0] RCTL_DATA = 8'h01;
  localparam logic [7:0] RCTL_CMD  = 8'h06;
  localparam logic [7:0] RCTL_RSP  = 8'h07;

  localparam logic [31:0] CRC_POLY = 32'h04C11DB7;
  localparam logic [31:0] CRC_SEED = 32'hFFFFFFFF;

  // One 32-bit word folded into the running CRC, MSB first.
  function automatic logic [31:0] crc_fold(input logic [31:0] cur, input logic [31:0] w);
    logic [31:0] r;
    logic        fb;
    r = cur;
    for (int i = 31; i >= 0; i--) begin
      fb = r[31] ^ w[i];
      r  = {r[30:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction

  function automatic region_t pick_region(input logic [7:0] rctl);
    case (rctl)
      RCTL_DATA: return RG_DATA;
      RCTL_CMD:  return RG_CMD;
      RCTL_RSP:  return RG_RSP;
      default:   return RG_GEN;
    endcase
  endfunction
endpackage

// File: rtl/rxfr_framer.sv
module rxfr_framer
  import rxfr_pkg::*;
#(
  parameter int HDR_WORDS     = 6,
  parameter int MAX_PAY_WORDS = 528,
  localparam int STRIDE       = HDR_WORDS + MAX_PAY_WORDS,
  localparam int OFF_W        = $clog2(STRIDE + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic [31:0]      in_data,
  input  logic [NREG-1:0]  region_full,
  output logic             wr_en,
  output region_t          wr_region,
  output logic [OFF_W-1:0] wr_off,
  output logic [31:0]      wr_data,
  output logic             commit,
  output region_t          commit_region,
  output logic [OFF_W-1:0] commit_len,
  output logic             ovf_hit
);
  localparam logic [OFF_W-1:0] STRIDE_O = OFF_W'(STRIDE);
  localparam logic [OFF_W-1:0] HDR_O    = OFF_W'(HDR_WORDS);

  logic             open_q, open_d;
  region_t          reg_q, reg_d;
  logic [OFF_W-1:0] off_q, off_d;
  logic [31:0]      crc_q, crc_d;
  logic             long_q, long_d;
  region_t          sof_region;

  assign sof_region = pick_region(in_data[31:24]);

  always_comb begin
    open_d        = open_q;
    reg_d         = reg_q;
    off_d         = off_q;
    crc_d         = crc_q;
    long_d        = long_q;
    wr_en         = 1'b0;
    wr_region     = reg_q;
    wr_off        = off_q;
    wr_data       = in_data;
    commit        = 1'b0;
    commit_region = reg_q;
    commit_len    = off_q - HDR_O;
    ovf_hit       = 1'b0;
    if (in_valid) begin
      if (in_sof) begin
        if (region_full[sof_region]) begin
          ovf_hit = 1'b1;
          open_d  = 1'b0;
        end else begin
          wr_en     = 1'b1;
          wr_region = sof_region;
          wr_off    = '0;
          reg_d     = sof_region;
          off_d     = OFF_W'(1);
          crc_d     = crc_fold(CRC_SEED, in_data);
          long_d    = 1'b0;
          open_d    = !in_eof;
        end
      end else if (open_q) begin
        if (in_eof) begin
          open_d = 1'b0;
          if (!long_q && off_q >= HDR_O && crc_q == in_data) commit = 1'b1;
        end else begin
          crc_d = crc_fold(crc_q, in_data);
          if (off_q < STRIDE_O) begin
            wr_en = 1'b1;
            off_d = off_q + 1'b1;
          end else begin
            long_d = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      reg_q  <= RG_GEN;
      off_q  <= '0;
      crc_q  <= CRC_SEED;
      long_q <= 1'b0;
    end else begin
      open_q <= open_d;
      reg_q  <= reg_d;
      off_q  <= off_d;
      crc_q  <= crc_d;
      long_q <= long_d;
    end
  end

  assert_wr_bound_R3: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> wr_off < STRIDE_O);
  assert_commit_len_R3: assert property (@(posedge clk) disable iff (rst)
    commit |-> (commit_len <= OFF_W'(MAX_PAY_WORDS)) && in_eof);
endmodule

// File: rtl/rxfr_region_store.sv
module rxfr_region_store #(
  parameter int NSLOT   = 2,
  parameter int STRIDE  = 534,
  localparam int OFF_W  = $clog2(STRIDE + 1),
  localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int CNT_W  = $clog2(NSLOT + 1),
  localparam int DEPTH  = NSLOT * STRIDE,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [31:0]       wr_data,
  input  logic              commit,
  input  logic              release_req,
  input  logic [SLOT_W-1:0] rd_slot,
  input  logic [OFF_W-1:0]  rd_word,
  output logic [31:0]       rd_data,
  output logic              full,
  output logic              rel_ok,
  output logic [SLOT_W-1:0] tail_slot
);
  localparam logic [CNT_W-1:0]  NSLOT_C = CNT_W'(NSLOT);
  localparam logic [SLOT_W-1:0] LAST_S  = SLOT_W'(NSLOT - 1);

  logic [31:0]       mem [DEPTH];
  logic [SLOT_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0]  count_q;
  logic [ADDR_W-1:0] wa, ra;

  assign wa        = ADDR_W'(tail_q) * ADDR_W'(STRIDE) + ADDR_W'(wr_off);
  assign ra        = ADDR_W'(rd_slot) * ADDR_W'(STRIDE) + ADDR_W'(rd_word);
  assign full      = (count_q == NSLOT_C);
  assign rel_ok    = release_req && (count_q != '0);
  assign tail_slot = tail_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wa] <= wr_data;
    rd_data <= mem[ra];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (commit) tail_q <= (tail_q == LAST_S) ? '0 : tail_q + 1'b1;
      if (rel_ok) head_q <= (head_q == LAST_S) ? '0 : head_q + 1'b1;
      case ({commit, rel_ok})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assert_no_commit_when_full_R7: assert property (@(posedge clk) disable iff (rst)
    commit |-> !full);
  assert_release_empty_R8: assert property (@(posedge clk) disable iff (rst)
    (release_req && count_q == '0 && !commit) |=> count_q == '0);
endmodule

// File: rtl/rxfr_credit.sv
module rxfr_credit #(
  parameter int CRED_INIT = 8,
  parameter int OVF_W     = 16,
  localparam int CRED_W   = $clog2(CRED_INIT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  logic              rel_ok,
  input  logic              ovf_hit,
  output logic [CRED_W-1:0] credit,
  output logic              rrdy_req,
  output logic [OVF_W-1:0]  ovf_count
);
  logic [CRED_W-1:0] cred_q;
  logic              rrdy_q;
  logic [OVF_W-1:0]  ovf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cred_q <= CRED_W'(CRED_INIT);
      rrdy_q <= 1'b0;
      ovf_q  <= '0;
    end else begin
      rrdy_q <= rel_ok;
      case ({commit, rel_ok})
        2'b10:   cred_q <= cred_q - 1'b1;
        2'b01:   cred_q <= cred_q + 1'b1;
        default: cred_q <= cred_q;
      endcase
      if (ovf_hit) ovf_q <= ovf_q + 1'b1;
    end
  end

  assign credit    = cred_q;
  assign rrdy_req  = rrdy_q;
  assign ovf_count = ovf_q;

  assert_rrdy_credit_R8: assert property (@(posedge clk) disable iff (rst)
    rrdy_q |-> cred_q == CRED_W'($past(cred_q) + CRED_W'(1) - CRED_W'($past(commit))));
  assert_ovf_step_R7: assert property (@(posedge clk) disable iff (rst)
    (ovf_q == $past(ovf_q)) || (ovf_q == $past(ovf_q) + 1'b1));
endmodule

// File: rtl/rxfr_router.sv
module rxfr_router
  import rxfr_pkg::*;
#(
  parameter int HDR_WORDS     = 6,
  parameter int MAX_PAY_WORDS = 528,
  parameter int NSLOT         = 2,
  parameter int OVF_W         = 16,
  localparam int STRIDE       = HDR_WORDS + MAX_PAY_WORDS,
  localparam int OFF_W        = $clog2(STRIDE + 1),
  localparam int SLOT_W       = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int CRED_INIT    = 4 * NSLOT,
  localparam int CRED_W       = $clog2(CRED_INIT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [31:0]       in_data,
  input  logic              rel_valid,
  input  logic [1:0]        rel_region,
  input  logic [1:0]        rd_region,
  input  logic [SLOT_W-1:0] rd_slot,
  input  logic [OFF_W-1:0]  rd_word,
  output logic [31:0]       rd_data,
  output logic              cmt_valid,
  output logic [1:0]        cmt_region,
  output logic [SLOT_W-1:0] cmt_slot,
  output logic [OFF_W-1:0]  cmt_len,
  output logic              rrdy_req,
  output logic [CRED_W-1:0] credit,
  output logic [OVF_W-1:0]  ovf_count
);
  logic             wr_en, commit, ovf_hit;
  region_t          wr_region, commit_region;
  logic [OFF_W-1:0] wr_off, commit_len;
  logic [31:0]      wr_data;
  logic [NREG-1:0]  full_v, rel_ok_v;
  logic [SLOT_W-1:0] tail_v [NREG];
  logic [31:0]      rd_v [NREG];
  region_t          rd_sel_q;

  rxfr_framer #(.HDR_WORDS(HDR_WORDS), .MAX_PAY_WORDS(MAX_PAY_WORDS)) framer_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
    .in_data(in_data), .region_full(full_v), .wr_en(wr_en), .wr_region(wr_region),
    .wr_off(wr_off), .wr_data(wr_data), .commit(commit), .commit_region(commit_region),
    .commit_len(commit_len), .ovf_hit(ovf_hit)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_region
    rxfr_region_store #(.NSLOT(NSLOT), .STRIDE(STRIDE)) store_i (
      .clk(clk), .rst(rst),
      .wr_en(wr_en && wr_region == region_t'(g)),
      .wr_off(wr_off), .wr_data(wr_data),
      .commit(commit && commit_region == region_t'(g)),
      .release_req(rel_valid && rel_region == region_t'(g)),
      .rd_slot(rd_slot), .rd_word(rd_word), .rd_data(rd_v[g]),
      .full(full_v[g]), .rel_ok(rel_ok_v[g]), .tail_slot(tail_v[g])
    );
  end

  rxfr_credit #(.CRED_INIT(CRED_INIT), .OVF_W(OVF_W)) credit_i (
    .clk(clk), .rst(rst), .commit(commit), .rel_ok(|rel_ok_v), .ovf_hit(ovf_hit),
    .credit(credit), .rrdy_req(rrdy_req), .ovf_count(ovf_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmt_valid  <= 1'b0;
      cmt_region <= RG_GEN;
      cmt_slot   <= '0;
      cmt_len    <= '0;
      rd_sel_q   <= RG_GEN;
    end else begin
      cmt_valid  <= commit;
      rd_sel_q   <= rd_region;
      if (commit) begin
        cmt_region <= commit_region;
        cmt_slot   <= tail_v[commit_region];
        cmt_len    <= commit_len;
      end
    end
  end

  assign rd_data = rd_v[rd_sel_q];

  assert_cmt_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    cmt_valid |-> $past(in_valid) && $past(in_eof));
  assert_credit_drop_R9: assert property (@(posedge clk) disable iff (rst)
    (cmt_valid && !rrdy_req) |-> credit == $past(credit) - 1'b1);
endmodule

// File: tb/rxfr_router_tb_top.sv
module rxfr_router_tb_top;
  localparam int HDR   = 6;
  localparam int MAXP  = 8;
  localparam int NSL   = 2;
  localparam int OFF_W = $clog2(HDR + MAXP + 1);
  localparam int SLW   = 1;
  localparam int CRW   = $clog2(4 * NSL + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [31:0] in_data = '0;
  logic rel_valid = 1'b0;
  logic [1:0] rel_region = '0, rd_region = '0;
  logic [SLW-1:0] rd_slot = '0;
  logic [OFF_W-1:0] rd_word = '0;
  logic [31:0] rd_data;
  logic cmt_valid, rrdy_req;
  logic [1:0] cmt_region;
  logic [SLW-1:0] cmt_slot;
  logic [OFF_W-1:0] cmt_len;
  logic [CRW-1:0] credit;
  logic [15:0] ovf_count;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rxfr_router #(.HDR_WORDS(HDR), .MAX_PAY_WORDS(MAXP), .NSLOT(NSL)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
    .in_data(in_data), .rel_valid(rel_valid), .rel_region(rel_region),
    .rd_region(rd_region), .rd_slot(rd_slot), .rd_word(rd_word), .rd_data(rd_data),
    .cmt_valid(cmt_valid), .cmt_region(cmt_region), .cmt_slot(cmt_slot),
    .cmt_len(cmt_len), .rrdy_req(rrdy_req), .credit(credit), .ovf_count(ovf_count)
  );

  // {rctl[7:0], payload words[7:0], bad crc, no end, expect commit, expect region[1:0]}
  localparam logic [20:0] VEC [8] = '{
    {8'h01, 8'd4, 1'b0, 1'b0, 1'b1, 2'd1},
    {8'h06, 8'd0, 1'b0, 1'b0, 1'b1, 2'd2},
    {8'h07, 8'd8, 1'b0, 1'b0, 1'b1, 2'd3},
    {8'h22, 8'd2, 1'b0, 1'b0, 1'b1, 2'd0},
    {8'h01, 8'd3, 1'b1, 1'b0, 1'b0, 2'd1},
    {8'h06, 8'd9, 1'b0, 1'b0, 1'b0, 2'd2},
    {8'h07, 8'd1, 1'b0, 1'b1, 1'b0, 2'd3},
    {8'h01, 8'd5, 1'b0, 1'b0, 1'b1, 2'd1}
  };

  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [31:0] w);
    logic [31:0] r = c;
    for (int b = 31; b >= 0; b--) begin
      if (r[31] != w[b]) r = (r << 1) ^ 32'h04C11DB7;
      else               r = r << 1;
    end
    return r;
  endfunction

  function automatic logic [31:0] word_of(input logic [7:0] rctl, input int seed, input int i);
    if (i == 0) return {rctl, 8'h00, seed[15:0]};
    return 32'hA5000000 ^ (seed << 8) ^ (i * 32'h01010101);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic [7:0] rctl, input int pay, input logic bad,
                            input logic noeof, input int seed);
    logic [31:0] c = 32'hFFFFFFFF;
    logic [31:0] w;
    for (int i = 0; i < HDR + pay; i++) begin
      w = word_of(rctl, seed, i);
      c = ref_crc(c, w);
      @(negedge clk);
      in_valid = 1'b1; in_sof = (i == 0); in_eof = 1'b0; in_data = w;
    end
    if (!noeof) begin
      @(negedge clk);
      in_sof = 1'b0; in_eof = 1'b1; in_data = bad ? ~c : c;
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic release_region(input logic [1:0] r, input logic exp_rrdy,
                                input logic [CRW-1:0] exp_cred);
    @(negedge clk);
    rel_valid = 1'b1; rel_region = r;
    @(negedge clk);
    rel_valid = 1'b0;
    check("R8 rrdy pulse", 32'(rrdy_req), 32'(exp_rrdy));
    check("R8 credit after release", 32'(credit), 32'(exp_cred));
  endtask

  task automatic read_word(input logic [1:0] r, input logic [SLW-1:0] s, input int wd,
                           input logic [31:0] exp, input string req);
    @(negedge clk);
    rd_region = r; rd_slot = s; rd_word = OFF_W'(wd);
    @(negedge clk);
    check(req, rd_data, exp);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [SLW-1:0] slot_a;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R9 reset credit", 32'(credit), 32'(4 * NSL));
    check("R9 reset ovf", 32'(ovf_count), 0);
    check("R9 reset rrdy", 32'(rrdy_req), 0);
    check("R9 reset cmt", 32'(cmt_valid), 0);

    for (int v = 0; v < 8; v++) begin
      logic [20:0] e = VEC[v];
      string tag;
      send_frame(e[20:13], int'(e[12:5]), e[4], e[3], v + 1);
      tag = e[4] ? "R2 crc" : (e[12:5] > MAXP) ? "R3 length" : e[3] ? "R4 no end" : "R6 commit";
      check(tag, 32'(cmt_valid), 32'(e[2]));
      if (e[2]) begin
        check("R5 region", 32'(cmt_region), 32'(e[1:0]));
        check("R1 length", 32'(cmt_len), 32'(e[12:5]));
        check("R9 credit after commit", 32'(credit), 32'(4 * NSL - 1));
        release_region(e[1:0], 1'b1, CRW'(4 * NSL));
      end
    end

    // R7 overflow into a full region
    send_frame(8'h01, 3, 1'b0, 1'b0, 100);
    slot_a = cmt_slot;
    check("R6 fill first", 32'(cmt_valid), 1);
    send_frame(8'h01, 2, 1'b0, 1'b0, 101);
    check("R6 fill second", 32'(cmt_valid), 1);
    check("R9 credit two held", 32'(credit), 32'(4 * NSL - 2));
    send_frame(8'h01, 1, 1'b0, 1'b0, 102);
    check("R7 dropped", 32'(cmt_valid), 0);
    check("R7 ovf count", 32'(ovf_count), 1);
    check("R7 credit unchanged", 32'(credit), 32'(4 * NSL - 2));
    send_frame(8'h07, 0, 1'b0, 1'b0, 103);
    check("R5 other region open", 32'(cmt_region), 3);
    release_region(2'd3, 1'b1, CRW'(4 * NSL - 2));

    // R10 / R1 read back
    read_word(2'd1, slot_a, 0, word_of(8'h01, 100, 0), "R10 header word");
    read_word(2'd1, slot_a, HDR, word_of(8'h01, 100, HDR), "R1 first payload");
    read_word(2'd1, slot_a, HDR + 2, word_of(8'h01, 100, HDR + 2), "R1 last payload");

    // R8 releases, then release of an empty region
    release_region(2'd1, 1'b1, CRW'(4 * NSL - 1));
    @(negedge clk);
    check("R8 rrdy one cycle", 32'(rrdy_req), 0);
    release_region(2'd1, 1'b1, CRW'(4 * NSL));
    release_region(2'd1, 1'b0, CRW'(4 * NSL));

    // R3 short frames
    @(negedge clk);
    in_valid = 1'b1; in_sof = 1'b1; in_eof = 1'b1; in_data = 32'h06000000;
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    check("R3 one word frame", 32'(cmt_valid), 0);
    send_frame(8'h06, -2, 1'b0, 1'b0, 104);
    check("R3 short header", 32'(cmt_valid), 0);

    // R4 abandoned frame then fresh frame
    send_frame(8'h22, 3, 1'b0, 1'b1, 105);
    send_frame(8'h22, 1, 1'b0, 1'b0, 106);
    check("R4 new frame commits", 32'(cmt_valid), 1);
    check("R4 new frame length", 32'(cmt_len), 1);
    slot_a = cmt_slot;
    read_word(2'd0, slot_a, 0, word_of(8'h22, 106, 0), "R4 header of new frame");
    release_region(2'd0, 1'b1, CRW'(4 * NSL));

    // R11 stray words outside a frame
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = 1'b0; in_eof = (k == 2); in_data = 32'h01000000 + k;
      @(negedge clk);
      in_valid = 1'b0; in_eof = 1'b0;
      check("R11 stray ignored", 32'(cmt_valid), 0);
    end
    check("R11 credit unchanged", 32'(credit), 32'(4 * NSL));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule